// File: doc/BRIEF.md
# Framed Parallel CRC Engine

This block computes a cyclic redundancy check over a message that arrives one M-bit word per clock. A start pulse and an end pulse, each qualified by the data-valid input, mark the first and last words of the message. Every accepted word is folded into an N-bit running remainder in a single cycle. The fold is the serial shift-register division unrolled across all M bits of the word.

On the cycle after the last word, a one-cycle result flag rises and the remainder is the finished checksum. Beats with data-valid low are skipped and leave the remainder as it was. The checksum then stays on the output until the next message starts.

Parameters set the polynomial, the CRC width, the seed, the bit order inside a word, the active clock edge and the reset polarity. The same block serves a transmitter that appends a checksum and a receiver that recomputes one for comparison.

Top module: `crc_frame_engine`

## Requirements
- R1: While reset is active at an active clock edge, the remainder becomes INIT and `crc_ok` is 0. Reset is active-high when RST_LOW=0 and active-low when RST_LOW=1, and it is synchronous.
- R2: A beat with `sof`=1 and `din_vld`=1 seeds from INIT. The next remainder is fold(INIT, din), whatever the previous remainder was. A `sof` with `din_vld`=0 has no effect.
- R3: A valid beat inside a message sets the remainder to fold(previous, din). fold shifts in one data bit at a time: fb = rem[N-1] ^ bit, rem is shifted left by one, and POLY (the polynomial without its x^N term) is XORed in when fb=1. With the defaults (N=32, POLY=04C11DB7, INIT all ones, MSB first) the ASCII string "123456789" gives 0376E6E7.
- R4: A beat with `din_vld`=0 leaves the remainder unchanged and does not raise `crc_ok`, whatever the values on `din`, `sof` and `eof`.
- R5: A beat with `eof`=1 and `din_vld`=1 inside a message raises `crc_ok` for exactly the next cycle. In that cycle `crc` holds the final checksum.
- R6: Between the end of a message and the next valid `sof`, valid words are ignored, including words with `eof`=1. `crc` keeps the final checksum and `crc_ok` stays 0.
- R7: With LSB_FIRST=0, fold takes din[M-1] first and din[0] last. With LSB_FIRST=1, it takes din[0] first.
- R8: With NEG_EDGE=1, all state changes on the falling edge of `clk`. With NEG_EDGE=0, all state changes on the rising edge.
- R9: A single valid beat carrying both `sof` and `eof` is a complete one-word message. The checksum is fold(INIT, din) and is flagged on the next cycle.
- R10: A valid `sof` in the middle of a message abandons the partial remainder and restarts the message from INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the active edge is chosen by NEG_EDGE |
| rst | input | 1 | Synchronous reset; the polarity is chosen by RST_LOW |
| sof | input | 1 | First word of a message, qualified by din_vld |
| eof | input | 1 | Last word of a message, qualified by din_vld |
| din | input | M | Data word |
| din_vld | input | 1 | Qualifies din, sof and eof |
| crc | output | N | Running remainder; final checksum when crc_ok is 1 |
| crc_ok | output | 1 | One-cycle flag that the checksum is complete |

## Verification
The embedded properties check several rules on every active edge:
- an idle beat freezes the remainder and keeps the flag low;
- the flag follows a qualified end beat, and never appears without one;
- the remainder holds while outside a message;
- reset returns the seed.

The checksum values themselves can be shown only by the bench scenarios, which compare against an independent bit-serial model. These scenarios cover:
- the standard check string;
- one-word messages;
- restarts in mid-message;
- messages with random gaps;
- a second configuration that uses LSB-first order, the falling clock edge, active-low reset and a word width that is not a power of two.

// File: rtl/crc_frame_engine.sv
module crc_frame_engine #(
  parameter int          N         = 32,
  parameter int          M         = 8,
  parameter logic [N-1:0] POLY     = 32'h04C11DB7,
  parameter logic [N-1:0] INIT     = '1,
  parameter bit          LSB_FIRST = 1'b0,
  parameter bit          NEG_EDGE  = 1'b0,
  parameter bit          RST_LOW   = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sof,
  input  logic         eof,
  input  logic [M-1:0] din,
  input  logic         din_vld,
  output logic [N-1:0] crc,
  output logic         crc_ok
);

  function automatic logic [N-1:0] fold(input logic [N-1:0] r, input logic [M-1:0] w);
    logic fb;
    for (int i = 0; i < M; i++) begin
      fb = r[N-1] ^ (LSB_FIRST ? w[i] : w[M-1-i]);
      r  = {r[N-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return r;
  endfunction

  logic         rst_on, in_frame, take;
  logic [N-1:0] rem, rem_d;
  logic         frm_d, ok_d;

  assign rst_on = RST_LOW ? ~rst : rst;
  assign take   = din_vld & (sof | in_frame);
  assign crc    = rem;

  always_comb begin
    rem_d = rem;
    frm_d = in_frame;
    ok_d  = 1'b0;
    if (take)
      rem_d = fold(sof ? INIT : rem, din);
    if (din_vld) begin
      if (sof)      frm_d = ~eof;
      else if (eof) frm_d = 1'b0;
      ok_d = eof & (sof | in_frame);
    end
    if (rst_on) begin
      rem_d = INIT;
      frm_d = 1'b0;
      ok_d  = 1'b0;
    end
  end

  generate
    if (NEG_EDGE) begin : g_fall
      always_ff @(negedge clk) begin
        rem      <= rem_d;
        in_frame <= frm_d;
        crc_ok   <= ok_d;
      end
    end else begin : g_rise
      always_ff @(posedge clk) begin
        rem      <= rem_d;
        in_frame <= frm_d;
        crc_ok   <= ok_d;
      end
    end
  endgenerate

  logic aclk;
  assign aclk = NEG_EDGE ? ~clk : clk;

  // R1
  reset_seed_chk: assert property (@(posedge aclk)
    rst_on |=> (crc == INIT && !crc_ok));

  // R4
  idle_hold_chk: assert property (@(posedge aclk) disable iff (rst_on)
    !din_vld |=> ($stable(crc) && !crc_ok));

  // R5
  flag_follows_end_chk: assert property (@(posedge aclk) disable iff (rst_on)
    (din_vld && eof && (sof || in_frame)) |=> crc_ok);

  // R5
  no_spurious_flag_chk: assert property (@(posedge aclk) disable iff (rst_on)
    !(din_vld && eof) |=> !crc_ok);

  // R6
  outside_hold_chk: assert property (@(posedge aclk) disable iff (rst_on)
    (!in_frame && !sof) |=> $stable(crc));

endmodule

// File: tb/crc_frame_engine_test.sv
`timescale 1ns/1ps
module crc_frame_engine_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int vectors = 0, errors = 0;

  // configuration A: defaults (rising edge, active-high reset, MSB first)
  logic        rst, sof, eof, vld;
  logic [7:0]  din;
  logic [31:0] crc;
  logic        ok;
  crc_frame_engine uut (.clk(clk), .rst(rst), .sof(sof), .eof(eof), .din(din),
                        .din_vld(vld), .crc(crc), .crc_ok(ok));

  // configuration B: falling edge, active-low reset, LSB first, 12-bit words
  logic        rstn2, sof2, eof2, vld2;
  logic [11:0] din2;
  logic [15:0] crc2;
  logic        ok2;
  crc_frame_engine #(.N(16), .M(12), .POLY(16'h8005), .INIT(16'h0000),
                     .LSB_FIRST(1'b1), .NEG_EDGE(1'b1), .RST_LOW(1'b1))
    uut2 (.clk(clk), .rst(rstn2), .sof(sof2), .eof(eof2), .din(din2),
          .din_vld(vld2), .crc(crc2), .crc_ok(ok2));

  localparam logic [31:0] INIT_A = 32'hFFFFFFFF, POLY_A = 32'h04C11DB7;

  function automatic logic [31:0] mstep(logic [31:0] r, logic [31:0] w, int n, int m,
                                        logic [31:0] poly, bit lsb);
    logic [63:0] mask = (64'd1 << n) - 64'd1;
    for (int i = 0; i < m; i++) begin
      bit b  = lsb ? w[i] : w[m-1-i];
      bit fb = r[n-1] ^ b;
      r = 32'((64'(r) << 1) & mask);
      if (fb) r = r ^ poly;
    end
    return r;
  endfunction

  function automatic logic [31:0] fa(logic [31:0] r, logic [7:0] w);
    return mstep(r, 32'(w), 32, 8, POLY_A, 1'b0);
  endfunction

  function automatic logic [31:0] fb2(logic [31:0] r, logic [11:0] w);
    return mstep(r, 32'(w), 16, 12, 32'h8005, 1'b1);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic beat(bit s, bit e, bit v, logic [7:0] d);
    @(negedge clk);
    sof = s; eof = e; vld = v; din = d;
  endtask

  // waits one cycle with an idle beat; the outputs then reflect the previous beat
  task automatic idle();
    beat(1'($urandom), 1'($urandom), 1'b0, 8'($urandom));
  endtask

  task automatic frame_a(int n, bit gaps, output logic [31:0] exp);
    exp = INIT_A;
    for (int i = 0; i < n; i++) begin
      logic [7:0] w = 8'($urandom);
      if (gaps && i > 0)
        while ($urandom_range(0, 2) == 0) idle();  // R4
      beat(i == 0, i == n - 1, 1'b1, w);
      exp = fa(exp, w);
    end
  endtask

  task automatic close_a(logic [31:0] exp, string tag);
    idle();
    chk({tag, " R5 flag"}, 32'(ok), 32'd1);
    chk({tag, " R3 value"}, crc, exp);
    idle();
    chk("R5 flag pulse", 32'(ok), 32'd0);
    chk("R5 hold", crc, exp);
  endtask

  task automatic beat2(bit s, bit e, bit v, logic [11:0] d);
    @(posedge clk);
    sof2 = s; eof2 = e; vld2 = v; din2 = d;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] exp;
    logic [7:0]  msg [9];
    void'($urandom(32'd2024));
    rst = 1; sof = 0; eof = 0; vld = 0; din = 0;
    rstn2 = 0; sof2 = 0; eof2 = 0; vld2 = 0; din2 = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset crc", crc, INIT_A);
    chk("R1 reset flag", 32'(ok), 32'd0);
    rst = 0;

    // R3 / R7: standard check string, MSB first
    foreach (msg[i]) msg[i] = 8'h31 + 8'(i);
    foreach (msg[i]) beat(i == 0, i == 8, 1'b1, msg[i]);
    close_a(32'h0376E6E7, "check string");

    // R6: valid words and an end marker outside a message
    for (int i = 0; i < 4; i++) beat(1'b0, i == 3, 1'b1, 8'($urandom));
    idle();
    chk("R6 outside words ignored", crc, 32'h0376E6E7);
    chk("R6 no flag outside", 32'(ok), 32'd0);

    // R2: sof without valid has no effect
    beat(1'b1, 1'b0, 1'b0, 8'hA5);
    beat(1'b0, 1'b0, 1'b1, 8'h5A);
    idle();
    chk("R2 unqualified sof ignored", crc, 32'h0376E6E7);

    // R9: single-word message
    beat(1'b1, 1'b1, 1'b1, 8'h3C);
    close_a(fa(INIT_A, 8'h3C), "R9 single word");

    // R2: the seed ignores the previous remainder
    beat(1'b1, 1'b0, 1'b1, 8'h77);
    idle();
    chk("R2 seed from INIT", crc, fa(INIT_A, 8'h77));

    // R10: restart in mid-message
    beat(1'b0, 1'b0, 1'b1, 8'h12);
    beat(1'b1, 1'b0, 1'b1, 8'h9E);
    beat(1'b0, 1'b1, 1'b1, 8'h40);
    close_a(fa(fa(INIT_A, 8'h9E), 8'h40), "R10 restart");

    // R1: reset in mid-message
    beat(1'b1, 1'b0, 1'b1, 8'h01);
    @(negedge clk); rst = 1; vld = 0;
    @(negedge clk);
    chk("R1 mid-message reset", crc, INIT_A);
    chk("R1 mid-message reset flag", 32'(ok), 32'd0);
    rst = 0;

    // random messages with gaps (R3, R4, R5, R6)
    for (int k = 0; k < 40; k++) begin
      frame_a($urandom_range(1, 12), 1'b1, exp);
      close_a(exp, "random gapped message");
      for (int j = 0; j < 2; j++) beat(1'b0, 1'($urandom), 1'b1, 8'($urandom));
      idle();
      chk("R6 hold after message", crc, exp);
    end

    // configuration B (R1, R7, R8)
    @(posedge clk);
    chk("R1 active-low reset", 32'(crc2), 32'h0);
    rstn2 = 1;
    beat2(1'b1, 1'b1, 1'b1, 12'h001);
    @(posedge clk);
    chk("R7 LSB-first word 001", 32'(crc2), fb2(0, 12'h001));
    chk("R8 falling-edge flag", 32'(ok2), 32'd1);
    for (int k = 0; k < 30; k++) begin
      int n = $urandom_range(1, 8);
      exp = 0;
      for (int i = 0; i < n; i++) begin
        logic [11:0] w = 12'($urandom);
        if (i > 0)
          while ($urandom_range(0, 2) == 0) beat2(1'($urandom), 1'($urandom), 1'b0, 12'($urandom));
        beat2(i == 0, i == n - 1, 1'b1, w);
        exp = fb2(exp, w);
      end
      beat2(1'b0, 1'b0, 1'b0, 12'h0);
      chk("R7 R8 config B value", 32'(crc2), exp);
      chk("R5 config B flag", 32'(ok2), 32'd1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule